// File: doc/BRIEF.md
# GPIO Port Pin-Resolution Controller

This block models one 16-line general-purpose I/O port behind a simple 32-bit register bus. Each line has a programmed mode, an output type, a pull setting and an output data bit. The value software reads back as input data is worked out from the programmed output, a per-line external drive event, whether the pin is currently attached to that external drive, and the pull resistors. Each resolved input bit is also driven out as a level signal for an interrupt or system-configuration block.

External drive arrives as a one-cycle event per line together with the level being applied. Whether an event is taken depends on the line's mode when the event arrives. A taken event attaches the pin and records the driven level. The set of detached pins is kept as a mask that software can overwrite and that is forced to all ones whenever a line becomes a push-pull output. Reset values of the mode, output type, pull and output data registers, and the value a floating unpulled line reads, are parameters of the port.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the registers hold their parameter values (defaults: mode 0xABFFFFFF, pull 0x64000000, output type 0, output data 0), the detach mask reads 0xFFFF and input data and `line_lvl` read 0x0000A000.
- R2: A line whose 2-bit mode field (bits 2i+1:2i of the mode register at word 0) is 01 (output) reads its output-data bit, except a push-pull/open-drain case in R6; writing output data while the line is not in output mode leaves its input bit unchanged.
- R3: A line in mode 00 (input) takes any drive event: its detach bit clears and its input bit follows the driven level from the next cycle.
- R4: A detached line not in output mode reads 1 with pull field 01, 0 with pull field 10, and the `FLOAT_DEF` bit (default 0) with pull field 00 or 11; the pull register is word 2, 2 bits per line.
- R5: A write that makes any line a push-pull output (mode 01, output-type bit at word 1 equal to 0) when it was not one before sets the whole detach mask to ones; drive events on push-pull lines are ignored.
- R6: On an open-drain output line (output-type bit 1) a high drive event is ignored; a low one clears the detach bit, and while attached the line reads output data AND the driven level, so 0.
- R7: A write to the detach mask (word 7, 1 = detached) replaces it and reads back the written lower 16 bits.
- R8: A write to word 5 sets output-data bits given in bits 15:0 and clears those given in bits 31:16, set winning when both are given; a write to word 6 clears the bits given in bits 15:0; words 5 and 6 read as 0. Output data reads back at word 3.
- R9: Input data (word 4) is read-only: writing it changes no register.
- R10: `line_lvl` always equals the input data value.
- R11: Lines in mode 10 or 11 ignore drive events and resolve like detached or attached input lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| pad_evt | input | 16 | Per-line external drive event, one cycle |
| pad_lvl | input | 16 | Level applied with each event |
| line_lvl | output | 16 | Resolved input level per line |

## Verification
The assertions check on every cycle that output lines not attached in open-drain mode read their output data, that detached pulled-up lines read high, that high drive events never attach a non-input line, that push-pull or other non-input non-open-drain lines never get attached, that a push-pull entry fills the mask, that set/clear writes land, and that writing input data leaves the registers alone. The reset values, the ordering of drive events against mode changes, the unpulled floating value, the read-as-zero words and the agreement of `line_lvl` with register reads are shown only by the bench, which replays directed sequences and a long random mix against its own model.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 4;
  localparam int BUS_W  = 32;
  localparam int HALF_W = 16;

  typedef enum logic [ADDR_W-1:0] {
    RA_MODE   = 4'd0,
    RA_OTYPE  = 4'd1,
    RA_PULL   = 4'd2,
    RA_ODATA  = 4'd3,
    RA_IDATA  = 4'd4,
    RA_SETCLR = 4'd5,
    RA_CLR    = 4'd6,
    RA_FLOAT  = 4'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    LM_IN  = 2'b00,
    LM_OUT = 2'b01,
    LM_ALT = 2'b10,
    LM_ANA = 2'b11
  } line_mode_e;

  localparam logic [1:0] PULL_UP = 2'b01;
  localparam logic [1:0] PULL_DN = 2'b10;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int N = 16,
  parameter logic [2*N-1:0] MODE_RST  = '0,
  parameter logic [N-1:0]   OTYPE_RST = '0,
  parameter logic [2*N-1:0] PULL_RST  = '0,
  parameter logic [N-1:0]   ODR_RST   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [2*N-1:0]    mode_q,
  output logic [N-1:0]      otype_q,
  output logic [2*N-1:0]    pull_q,
  output logic [N-1:0]      odr_q,
  output logic              pp_enter
);
  logic [2*N-1:0] mode_d, pull_d;
  logic [N-1:0]   otype_d, odr_d;
  logic           cfg_en;
  logic [N-1:0]   pp_now, pp_next;

  function automatic logic [N-1:0] pp_lines(input logic [2*N-1:0] m, input logic [N-1:0] t);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (m[2*i +: 2] == LM_OUT) && !t[i];
    return r;
  endfunction

  always_comb begin
    mode_d  = mode_q;
    otype_d = otype_q;
    pull_d  = pull_q;
    odr_d   = odr_q;
    if (wr_en) begin
      case (wr_addr)
        RA_MODE:   mode_d  = wr_data[2*N-1:0];
        RA_OTYPE:  otype_d = wr_data[N-1:0];
        RA_PULL:   pull_d  = wr_data[2*N-1:0];
        RA_ODATA:  odr_d   = wr_data[N-1:0];
        RA_SETCLR: odr_d   = (odr_q & ~wr_data[HALF_W +: N]) | wr_data[N-1:0];
        RA_CLR:    odr_d   = odr_q & ~wr_data[N-1:0];
        default:   ;
      endcase
    end
  end

  assign cfg_en   = wr_en;
  assign pp_now   = pp_lines(mode_q, otype_q);
  assign pp_next  = pp_lines(mode_d, otype_d);
  assign pp_enter = |(pp_next & ~pp_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RST;
      otype_q <= OTYPE_RST;
      pull_q  <= PULL_RST;
      odr_q   <= ODR_RST;
    end else if (cfg_en) begin
      mode_q  <= mode_d;
      otype_q <= otype_d;
      pull_q  <= pull_d;
      odr_q   <= odr_d;
    end
  end

  // R8
  setclr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RA_SETCLR) |=>
      ((odr_q & $past(wr_data[N-1:0])) == $past(wr_data[N-1:0])));

  // R8
  clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RA_CLR) |=> ((odr_q & $past(wr_data[N-1:0])) == '0));
endmodule

// File: rtl/gpio_pad_track.sv
module gpio_pad_track #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pad_evt,
  input  logic [N-1:0] pad_lvl,
  input  logic [N-1:0] in_line,
  input  logic [N-1:0] od_out,
  input  logic         pp_enter,
  input  logic         float_we,
  input  logic [N-1:0] float_wdata,
  output logic [N-1:0] float_q,
  output logic [N-1:0] ext_q
);
  logic [N-1:0] take, float_d, ext_d;
  logic         trk_en;

  always_comb begin
    take    = pad_evt & (in_line | (od_out & ~pad_lvl));
    float_d = float_q & ~take;
    ext_d   = (ext_q & ~take) | (pad_lvl & take);
    if (pp_enter) float_d = '1;
    if (float_we) float_d = float_wdata;
  end

  assign trk_en = |pad_evt | pp_enter | float_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      float_q <= '1;
      ext_q   <= '0;
    end else if (trk_en) begin
      float_q <= float_d;
      ext_q   <= ext_d;
    end
  end

  // R5
  pp_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_enter && !float_we) |=> (&float_q));

  // R6
  high_noattach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !float_we |=> ((($past(float_q) & ~float_q) & $past(pad_lvl & ~in_line)) == '0));

  // R5
  pp_noattach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !float_we |=> ((($past(float_q) & ~float_q) & $past(~in_line & ~od_out)) == '0));
endmodule

// File: rtl/gpio_line_resolve.sv
module gpio_line_resolve
  import gpio_port_pkg::*;
#(
  parameter int N = 16,
  parameter logic [N-1:0] FLOAT_DEF = '0
) (
  input  logic [2*N-1:0] mode_q,
  input  logic [N-1:0]   otype_q,
  input  logic [2*N-1:0] pull_q,
  input  logic [N-1:0]   odr_q,
  input  logic [N-1:0]   float_q,
  input  logic [N-1:0]   ext_q,
  output logic [N-1:0]   idr
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [1:0] m, p;
    logic       float_val;
    assign m = mode_q[2*i +: 2];
    assign p = pull_q[2*i +: 2];
    assign float_val = (p == PULL_UP) ? 1'b1 :
                       (p == PULL_DN) ? 1'b0 : FLOAT_DEF[i];
    always_comb begin
      if (m == LM_OUT)
        idr[i] = (otype_q[i] && !float_q[i]) ? (odr_q[i] & ext_q[i]) : odr_q[i];
      else
        idr[i] = float_q[i] ? float_val : ext_q[i];
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int N = 16,
  parameter logic [2*N-1:0] MODE_RST  = 32'hABFF_FFFF,
  parameter logic [N-1:0]   OTYPE_RST = '0,
  parameter logic [2*N-1:0] PULL_RST  = 32'h6400_0000,
  parameter logic [N-1:0]   ODR_RST   = '0,
  parameter logic [N-1:0]   FLOAT_DEF = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [N-1:0]      pad_evt,
  input  logic [N-1:0]      pad_lvl,
  output logic [N-1:0]      line_lvl
);
  logic           rst_i_n;
  logic [2*N-1:0] mode_q, pull_q;
  logic [N-1:0]   otype_q, odr_q, float_q, ext_q, idr;
  logic [N-1:0]   out_lines, in_lines, pu_lines, od_out;
  logic           pp_enter, float_we;

  gpio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  gpio_cfg_regs #(
    .N(N), .MODE_RST(MODE_RST), .OTYPE_RST(OTYPE_RST),
    .PULL_RST(PULL_RST), .ODR_RST(ODR_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_i_n), .wr_en(bus_we), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .mode_q(mode_q), .otype_q(otype_q),
    .pull_q(pull_q), .odr_q(odr_q), .pp_enter(pp_enter)
  );

  always_comb begin
    for (int i = 0; i < N; i++) begin
      out_lines[i] = (mode_q[2*i +: 2] == LM_OUT);
      in_lines[i]  = (mode_q[2*i +: 2] == LM_IN);
      pu_lines[i]  = (pull_q[2*i +: 2] == PULL_UP);
    end
  end

  assign od_out   = out_lines & otype_q;
  assign float_we = bus_we && (bus_addr == RA_FLOAT);

  gpio_pad_track #(.N(N)) u_pad (
    .clk(clk), .rst_n(rst_i_n), .pad_evt(pad_evt), .pad_lvl(pad_lvl),
    .in_line(in_lines), .od_out(od_out), .pp_enter(pp_enter),
    .float_we(float_we), .float_wdata(bus_wdata[N-1:0]),
    .float_q(float_q), .ext_q(ext_q)
  );

  gpio_line_resolve #(.N(N), .FLOAT_DEF(FLOAT_DEF)) u_res (
    .mode_q(mode_q), .otype_q(otype_q), .pull_q(pull_q), .odr_q(odr_q),
    .float_q(float_q), .ext_q(ext_q), .idr(idr)
  );

  assign line_lvl = idr;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_MODE:  bus_rdata[2*N-1:0] = mode_q;
      RA_OTYPE: bus_rdata[N-1:0]   = otype_q;
      RA_PULL:  bus_rdata[2*N-1:0] = pull_q;
      RA_ODATA: bus_rdata[N-1:0]   = odr_q;
      RA_IDATA: bus_rdata[N-1:0]   = idr;
      RA_FLOAT: bus_rdata[N-1:0]   = float_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R2
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((idr ^ odr_q) & out_lines & ~(otype_q & ~float_q)) == '0);

  // R4
  pullup_float_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (~out_lines & float_q & pu_lines & ~idr) == '0);

  // R9
  idata_ro_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_we && bus_addr == RA_IDATA) |=>
      (mode_q == $past(mode_q) && odr_q == $past(odr_q) &&
       pull_q == $past(pull_q) && otype_q == $past(otype_q)));
endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  logic        clk, rst_n, bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] pad_evt, pad_lvl, line_lvl;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] m_mode, m_pull;
  logic [15:0] m_otype, m_odr, m_float, m_ext;

  gpio_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_evt(pad_evt),
    .pad_lvl(pad_lvl), .line_lvl(line_lvl)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] pp_of(input logic [31:0] m, input logic [15:0] t);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = (m[2*i +: 2] == 2'b01) && !t[i];
    return r;
  endfunction

  function automatic logic [15:0] resolve();
    logic [15:0] r;
    for (int i = 0; i < 16; i++) begin
      logic [1:0] p;
      logic fv;
      p = m_pull[2*i +: 2];
      fv = (p == 2'b01) ? 1'b1 : 1'b0;
      if (m_mode[2*i +: 2] == 2'b01)
        r[i] = (m_otype[i] && !m_float[i]) ? (m_odr[i] & m_ext[i]) : m_odr[i];
      else
        r[i] = m_float[i] ? fv : m_ext[i];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [15:0] pb, pa;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    pb = pp_of(m_mode, m_otype);
    case (a)
      4'd0: m_mode  = d;
      4'd1: m_otype = d[15:0];
      4'd2: m_pull  = d;
      4'd3: m_odr   = d[15:0];
      4'd5: m_odr   = (m_odr & ~d[31:16]) | d[15:0];
      4'd6: m_odr   = m_odr & ~d[15:0];
      4'd7: m_float = d[15:0];
      default: ;
    endcase
    pa = pp_of(m_mode, m_otype);
    if ((pa & ~pb) != 16'h0) m_float = 16'hFFFF;
  endtask

  task automatic evt(input logic [15:0] e, input logic [15:0] l);
    @(negedge clk);
    pad_evt = e; pad_lvl = l;
    @(negedge clk);
    pad_evt = '0;
    for (int i = 0; i < 16; i++) begin
      if (e[i] && (m_mode[2*i +: 2] == 2'b00 ||
                   (m_mode[2*i +: 2] == 2'b01 && m_otype[i] && !l[i]))) begin
        m_float[i] = 1'b0;
        m_ext[i]   = l[i];
      end
    end
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    rd(4'd4, d); check({req, " idata"}, d, {16'h0, resolve()});
    check({"R10 ", req}, {16'h0, line_lvl}, {16'h0, resolve()});
    rd(4'd7, d); check({req, " mask"}, d, {16'h0, m_float});
    rd(4'd3, d); check({req, " odata"}, d, {16'h0, m_odr});
  endtask

  initial begin
    #(20 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_evt = '0; pad_lvl = '0;
    m_mode = 32'hABFF_FFFF; m_pull = 32'h6400_0000;
    m_otype = '0; m_odr = '0; m_float = 16'hFFFF; m_ext = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(4'd0, d); check("R1 mode", d, 32'hABFF_FFFF);
    rd(4'd2, d); check("R1 pull", d, 32'h6400_0000);
    rd(4'd1, d); check("R1 otype", d, 32'h0);
    rd(4'd3, d); check("R1 odata", d, 32'h0);
    rd(4'd7, d); check("R1 mask", d, 32'h0000_FFFF);
    rd(4'd4, d); check("R1 idata", d, 32'h0000_A000);
    check("R1 R10 line_lvl", {16'h0, line_lvl}, 32'h0000_A000);

    // R2 output data only visible in output mode
    wr(4'd3, 32'h1);
    rd(4'd4, d); check("R2 odr not output", d, 32'h0000_A000);
    wr(4'd0, 32'hABFF_FFFD);
    rd(4'd4, d); check("R2 output mode", d, 32'h0000_A001);

    // R3 input follows drive
    wr(4'd3, 32'h0);
    wr(4'd0, 32'h0);
    evt(16'h0001, 16'h0001);
    rd(4'd4, d); check("R3 high", d, 32'h0000_A001);
    evt(16'h0001, 16'h0000);
    rd(4'd4, d); check("R3 low", d, 32'h0000_A000);
    rd(4'd7, d); check("R3 attached", d, 32'h0000_FFFE);

    // R4 pulls on detached lines
    wr(4'd7, 32'hFFFF);
    wr(4'd2, 32'h1);
    rd(4'd4, d); check("R4 pull-up", d, 32'h0000_0001);
    wr(4'd2, 32'h2);
    rd(4'd4, d); check("R4 pull-down", d, 32'h0000_0000);
    wr(4'd2, 32'h3);
    rd(4'd4, d); check("R4 code 11 floats", d, 32'h0000_0000);

    // R5 push-pull entry and ignored drive
    wr(4'd2, 32'h6400_0000);
    wr(4'd7, 32'h0000_0F00);
    wr(4'd0, 32'h1);
    rd(4'd7, d); check("R5 fill", d, 32'h0000_FFFF);
    evt(16'h0001, 16'h0001);
    rd(4'd7, d); check("R5 high ignored", d, 32'h0000_FFFF);
    evt(16'h0001, 16'h0000);
    rd(4'd7, d); check("R5 low ignored", d, 32'h0000_FFFF);
    wr(4'd3, 32'h1);
    rd(4'd4, d); check("R5 R2 odr", d, 32'h0000_A001);

    // R6 open drain
    wr(4'd1, 32'h1);
    rd(4'd7, d); check("R6 no refill", d, 32'h0000_FFFF);
    evt(16'h0001, 16'h0001);
    rd(4'd7, d); check("R6 high ignored", d, 32'h0000_FFFF);
    evt(16'h0001, 16'h0000);
    rd(4'd7, d); check("R6 low attaches", d, 32'h0000_FFFE);
    rd(4'd4, d); check("R6 forced low", d, 32'h0000_A000);

    // R7 mask write
    wr(4'd7, 32'h1234);
    rd(4'd7, d); check("R7 mask", d, 32'h0000_1234);

    // R8 set/clear
    wr(4'd3, 32'h00F0);
    wr(4'd5, 32'h0011_0101);
    rd(4'd3, d); check("R8 setclr", d, 32'h0000_01E1);
    rd(4'd5, d); check("R8 setclr reads 0", d, 32'h0);
    wr(4'd6, 32'h0021);
    rd(4'd3, d); check("R8 clr", d, 32'h0000_01C0);
    rd(4'd6, d); check("R8 clr reads 0", d, 32'h0);
    wr(4'd5, 32'h0001_0001);
    rd(4'd3, d); check("R8 set wins", d, 32'h0000_01C1);

    // R9 input data read-only
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd0, d); check("R9 mode kept", d, 32'h1);
    rd(4'd3, d); check("R9 odata kept", d, 32'h0000_01C1);

    // R11 alternate and analog ignore drive
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd7, 32'hFFFF);
    evt(16'hFFFF, 16'h0000);
    rd(4'd7, d); check("R11 analog ignored", d, 32'h0000_FFFF);
    wr(4'd0, 32'hAAAA_AAAA);
    evt(16'hFFFF, 16'hFFFF);
    rd(4'd7, d); check("R11 alt ignored", d, 32'h0000_FFFF);
    rd(4'd4, d); check("R11 R4 resolve", d, 32'h0000_A000);

    // random mix, checked against the model (R2-R8, R10, R11)
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [31:0] rv;
      op = int'($urandom % 9);
      rv = $urandom;
      case (op)
        0: wr(4'd0, rv);
        1: wr(4'd1, rv & 32'hFFFF);
        2: wr(4'd2, rv);
        3: wr(4'd5, rv);
        4: wr(4'd6, rv & 32'hFFFF);
        5: wr(4'd7, rv & 32'hFFFF);
        6: wr(4'd3, rv & 32'hFFFF);
        default: evt(rv[15:0], rv[31:16]);
      endcase
      check_all("R2-R6 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule